// File: doc/BRIEF.md
# Speculative Vector Region Replay Controller

This block sequences a speculatively vectorized code region. Retiring instructions report through one qualified event: a start marker, an end marker, or any other instruction. When a start marker retires, the controller stores the address of the instruction after it as the replay target. While the region is open, the execution side can report that some vector lanes read stale data. The controller ORs these reports into a needs-replay lane mask.

When the end marker retires, the controller looks at the collected mask. If the mask is all zero, it commits: the store buffer is told to release the held speculative stores, and execution continues past the region. If any lane is flagged, the controller sends fetch back to the stored address with a redirect strobe. It also pulses a squash strobe to the store buffer. The flagged lanes become the only active lanes for the next pass, so lanes that computed correctly are not run again, whether they sit above or below a failing lane. This repeats until a pass ends clean.

A start marker that arrives while a region is already open is an error. It sets a sticky flag and changes nothing else.

Top module: `specReplayCtl`

## Requirements
- R1: After reset the block is idle. `storeHold`, `redirectValid`, `commitStb`, `squashStb` and `nestErr` are low, and `activeLanes` is all ones.
- R2: A start event (`retireValid` high, `retireKind`=1) while idle opens a region on the next cycle. `storeHold` goes high, every lane is active, the needs-replay mask is empty, and `retirePc` is stored as the replay target.
- R3: While a region is open, a cycle with `violValid` high adds `violLanes` ANDed with `activeLanes` to the needs-replay mask. Reports on inactive lanes, and all reports while idle, have no effect.
- R4: An end event (`retireKind`=2) with an empty needs-replay mask pulses `commitStb` for one cycle on the next cycle. The region closes and `activeLanes` returns to all ones.
- R5: An end event with a non-empty needs-replay mask pulses `redirectValid` and `squashStb` for one cycle on the next cycle. `activeLanes` becomes exactly that mask, the mask is cleared, and the region stays open.
- R6: Rollback repeats without limit. Every redirect presents the replay target stored at region start on `redirectPc`.
- R7: `storeHold` is high in exactly the cycles a region is open, and it falls in the same cycle `commitStb` pulses.
- R8: A start event while a region is open sets the sticky `nestErr` (cleared only by reset). The stored target and the lanes stay unchanged, and violation reports in that cycle are still collected.
- R9: An end event while idle has no effect.
- R10: A violation reported in the same cycle as an end event counts toward that end's decision. A violation reported in the same cycle as a start event that opens a region is dropped.
- R11: `retireKind` 0 and 3 mean an ordinary instruction. No event is taken while `retireValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | A retire event is present |
| retireKind | input | 2 | 0 other, 1 region start, 2 region end, 3 other |
| retirePc | input | PC_W | Address of the instruction after the retiring one |
| violValid | input | 1 | Lane violation report present |
| violLanes | input | LANES | Lanes that read stale data |
| storeHold | output | 1 | Region open; store buffer keeps speculative data |
| activeLanes | output | LANES | Lanes enabled for the current pass |
| redirectValid | output | 1 | One-cycle rollback strobe |
| redirectPc | output | PC_W | Replay target address |
| commitStb | output | 1 | One-cycle release of speculative stores |
| squashStb | output | 1 | One-cycle discard of stores from the replayed lanes |
| nestErr | output | 1 | Sticky nested-start error |

## Verification
The bench builds the block with LANES=8 and PC_W=32. With eight lanes, sparse random violation masks often produce multi-pass rollbacks that shrink the active set one step at a time, and they still leave room for regions that commit clean. The 32-bit address lets every region carry a distinct random replay target, so a target that is kept across passes can be told apart from one that is reloaded by mistake.

// File: rtl/specReplayPkg.sv
package specReplayPkg;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_START = 2'd1,
    KIND_END   = 2'd2,
    KIND_RSVD  = 2'd3
  } retireKind_t;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic openRegion;   // load target, enable all lanes, clear needs
    logic accumulate;   // needs <= merged
    logic replayPass;   // active <= merged, needs <= 0
    logic closeRegion;  // active <= all ones, needs <= 0
  } dpCtl_t;

endpackage

// File: rtl/specReplayDp.sv
module specReplayDp
  import specReplayPkg::*;
#(
  parameter int LANES = 8,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [PC_W-1:0]  startPc,
  input  logic             violValid,
  input  logic [LANES-1:0] violLanes,
  output logic [PC_W-1:0]  replayPc,
  output logic [LANES-1:0] activeLanes,
  output logic             passClean
);

  logic [LANES-1:0] needsQ;
  logic [LANES-1:0] mergedNeeds;

  // replay target register
  always_ff @(posedge clk) begin
    if (!rstN)               replayPc <= '0;
    else if (ctl.openRegion) replayPc <= startPc;
  end

  // per-lane needs and active flags
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = violValid && violLanes[g] && activeLanes[g];
    assign mergedNeeds[g] = needsQ[g] | hit;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        needsQ[g]      <= 1'b0;
        activeLanes[g] <= 1'b1;
      end else if (ctl.openRegion) begin
        needsQ[g]      <= 1'b0;
        activeLanes[g] <= 1'b1;
      end else if (ctl.replayPass) begin
        needsQ[g]      <= 1'b0;
        activeLanes[g] <= mergedNeeds[g];
      end else if (ctl.closeRegion) begin
        needsQ[g]      <= 1'b0;
        activeLanes[g] <= 1'b1;
      end else if (ctl.accumulate) begin
        needsQ[g]      <= mergedNeeds[g];
      end
    end
  end

  assign passClean = (mergedNeeds == '0);

endmodule

// File: rtl/specReplayCtrl.sv
module specReplayCtrl
  import specReplayPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       retireValid,
  input  logic [1:0] retireKind,
  input  logic       passClean,
  output dpCtl_t     ctl,
  output logic       regionOpen,
  output logic       redirectValid,
  output logic       commitStb,
  output logic       squashStb,
  output logic       nestErr
);

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t      stateQ, stateD;
  retireKind_t kind;
  logic        isStart, isEnd, nestHit;

  assign kind    = retireKind_t'(retireKind);
  assign isStart = retireValid && (kind == KIND_START);
  assign isEnd   = retireValid && (kind == KIND_END);

  always_comb begin
    ctl     = '0;
    stateD  = stateQ;
    nestHit = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (isStart) begin
          ctl.openRegion = 1'b1;
          stateD         = ST_RUN;
        end
      end
      ST_RUN: begin
        if (isEnd) begin
          if (passClean) begin
            ctl.closeRegion = 1'b1;
            stateD          = ST_IDLE;
          end else begin
            ctl.replayPass = 1'b1;
          end
        end else begin
          ctl.accumulate = 1'b1;
          nestHit        = isStart;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ        <= ST_IDLE;
      redirectValid <= 1'b0;
      squashStb     <= 1'b0;
      commitStb     <= 1'b0;
      nestErr       <= 1'b0;
    end else begin
      stateQ        <= stateD;
      redirectValid <= ctl.replayPass;
      squashStb     <= ctl.replayPass;
      commitStb     <= ctl.closeRegion;
      nestErr       <= nestErr | nestHit;
    end
  end

  assign regionOpen = (stateQ == ST_RUN);

endmodule

// File: rtl/specReplayCtl.sv
module specReplayCtl
  import specReplayPkg::*;
#(
  parameter int LANES = 8,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic [1:0]       retireKind,
  input  logic [PC_W-1:0]  retirePc,
  input  logic             violValid,
  input  logic [LANES-1:0] violLanes,
  output logic             storeHold,
  output logic [LANES-1:0] activeLanes,
  output logic             redirectValid,
  output logic [PC_W-1:0]  redirectPc,
  output logic             commitStb,
  output logic             squashStb,
  output logic             nestErr
);

  dpCtl_t ctl;
  logic   passClean;

  specReplayCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .retireValid   (retireValid),
    .retireKind    (retireKind),
    .passClean     (passClean),
    .ctl           (ctl),
    .regionOpen    (storeHold),
    .redirectValid (redirectValid),
    .commitStb     (commitStb),
    .squashStb     (squashStb),
    .nestErr       (nestErr)
  );

  specReplayDp #(.LANES(LANES), .PC_W(PC_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .startPc     (retirePc),
    .violValid   (violValid),
    .violLanes   (violLanes),
    .replayPc    (redirectPc),
    .activeLanes (activeLanes),
    .passClean   (passClean)
  );

endmodule

// File: rtl/specReplayChk.sv
module specReplayChk #(
  parameter int LANES = 8,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             retireValid,
  input logic [1:0]       retireKind,
  input logic             storeHold,
  input logic [LANES-1:0] activeLanes,
  input logic             redirectValid,
  input logic [PC_W-1:0]  redirectPc,
  input logic             commitStb,
  input logic             squashStb,
  input logic             nestErr
);

  // R1: lanes are all enabled whenever no region is open
  a_r1_idle_lanes: assert property (@(posedge clk) disable iff (!rstN)
    !storeHold |-> (activeLanes == {LANES{1'b1}}));

  // R5: a replay pass enables a non-empty subset of the previous pass
  a_r5_replay_subset: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> ((activeLanes != '0) && ((activeLanes & ~$past(activeLanes)) == '0)));

  // R5: squash and redirect travel together, never with commit
  a_r5_squash_pair: assert property (@(posedge clk) disable iff (!rstN)
    (squashStb == redirectValid) && !(redirectValid && commitStb));

  // R6: the replay target does not move while the region stays open
  a_r6_pc_stable: assert property (@(posedge clk) disable iff (!rstN)
    (storeHold && $past(storeHold)) |-> $stable(redirectPc));

  // R7: commit coincides with store hold dropping
  a_r7_commit_release: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |-> (!storeHold && $past(storeHold)));

  // R7: store hold only falls through a commit
  a_r7_hold_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(storeHold) |-> commitStb);

  // R8: error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    nestErr |=> nestErr);

  // R9: an end event while idle changes nothing
  a_r9_idle_end: assert property (@(posedge clk) disable iff (!rstN)
    (!storeHold && retireValid && retireKind == 2'd2) |=> (!storeHold && !commitStb && !redirectValid));

endmodule

bind specReplayCtl specReplayChk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .retireValid   (retireValid),
  .retireKind    (retireKind),
  .storeHold     (storeHold),
  .activeLanes   (activeLanes),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .commitStb     (commitStb),
  .squashStb     (squashStb),
  .nestErr       (nestErr)
);

// File: tb/specReplayCtl_tb.sv
module specReplayCtl_tb;

  localparam int LANES = 8;
  localparam int PC_W  = 32;
  localparam logic [LANES-1:0] ALL = {LANES{1'b1}};

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             retireValid = 1'b0;
  logic [1:0]       retireKind = 2'd0;
  logic [PC_W-1:0]  retirePc = '0;
  logic             violValid = 1'b0;
  logic [LANES-1:0] violLanes = '0;
  logic             storeHold, redirectValid, commitStb, squashStb, nestErr;
  logic [LANES-1:0] activeLanes;
  logic [PC_W-1:0]  redirectPc;

  int errors = 0;
  int checks = 0;

  // reference model state
  logic             mActive = 1'b0;
  logic [PC_W-1:0]  mPc = '0;
  logic [LANES-1:0] mLanes = ALL;
  logic [LANES-1:0] mNeeds = '0;
  logic             mErr = 1'b0;
  logic             mRedir = 1'b0;
  logic             mCommit = 1'b0;

  always #2 clk = ~clk;

  specReplayCtl #(.LANES(LANES), .PC_W(PC_W)) u_dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireKind(retireKind),
    .retirePc(retirePc), .violValid(violValid), .violLanes(violLanes),
    .storeHold(storeHold), .activeLanes(activeLanes), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .commitStb(commitStb), .squashStb(squashStb), .nestErr(nestErr)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] mergeNeeds(input logic vv, input logic [LANES-1:0] vl);
    return mNeeds | (vv ? (vl & mLanes) : '0);
  endfunction

  task automatic modelStep(input logic v, input logic [1:0] k, input logic [PC_W-1:0] pc,
                           input logic vv, input logic [LANES-1:0] vl);
    logic isStart, isEnd;
    logic [LANES-1:0] merged;
    isStart = v && (k == 2'd1);
    isEnd   = v && (k == 2'd2);
    mRedir  = 1'b0;
    mCommit = 1'b0;
    merged  = mergeNeeds(vv, vl);
    if (!mActive) begin
      if (isStart) begin
        mActive = 1'b1; mPc = pc; mLanes = ALL; mNeeds = '0;
      end
    end else if (isEnd) begin
      if (merged == '0) begin
        mCommit = 1'b1; mActive = 1'b0; mLanes = ALL; mNeeds = '0;
      end else begin
        mRedir = 1'b1; mLanes = merged; mNeeds = '0;
      end
    end else begin
      if (isStart) mErr = 1'b1;
      mNeeds = merged;
    end
  endtask

  // drive at negedge, advance one edge, compare at the next negedge
  task automatic step(input string tag, input logic v, input logic [1:0] k,
                      input logic [PC_W-1:0] pc, input logic vv, input logic [LANES-1:0] vl);
    retireValid = v; retireKind = k; retirePc = pc; violValid = vv; violLanes = vl;
    modelStep(v, k, pc, vv, vl);
    @(posedge clk);
    @(negedge clk);
    chk(storeHold == mActive, {tag, " R2/R7 storeHold"}, 64'(storeHold), 64'(mActive));
    chk(activeLanes == mLanes, {tag, " R5 activeLanes"}, 64'(activeLanes), 64'(mLanes));
    chk(redirectValid == mRedir, {tag, " R5 redirectValid"}, 64'(redirectValid), 64'(mRedir));
    chk(squashStb == mRedir, {tag, " R5 squashStb"}, 64'(squashStb), 64'(mRedir));
    chk(commitStb == mCommit, {tag, " R4 commitStb"}, 64'(commitStb), 64'(mCommit));
    chk(nestErr == mErr, {tag, " R8 nestErr"}, 64'(nestErr), 64'(mErr));
    if (mRedir)
      chk(redirectPc == mPc, {tag, " R6 redirectPc"}, 64'(redirectPc), 64'(mPc));
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(storeHold == 1'b0 && redirectValid == 1'b0 && commitStb == 1'b0 &&
        squashStb == 1'b0 && nestErr == 1'b0, "R1 reset strobes", 64'(storeHold), 64'(0));
    chk(activeLanes == ALL, "R1 reset lanes", 64'(activeLanes), 64'(ALL));
    rstN = 1'b1;

    // R9 end while idle; R11 kind 3 and low valid ignored; R3 idle violation ignored
    step("R9", 1'b1, 2'd2, 32'h0, 1'b0, '0);
    step("R11", 1'b1, 2'd3, 32'h0, 1'b1, 8'hFF);
    step("R11", 1'b0, 2'd1, 32'h44, 1'b0, '0);
    chk(storeHold == 1'b0, "R11 no event when valid low", 64'(storeHold), 64'(0));

    // R2 open, clean end -> R4 commit
    step("R2", 1'b1, 2'd1, 32'h1000, 1'b0, '0);
    step("R4", 1'b1, 2'd2, 32'h0, 1'b0, '0);

    // R10 violation with opening start is dropped; R5/R6 multi-pass
    step("R10", 1'b1, 2'd1, 32'h2000, 1'b1, 8'h81);
    step("R3", 1'b1, 2'd0, 32'h0, 1'b1, 8'h24);
    step("R5", 1'b1, 2'd2, 32'h0, 1'b0, '0);
    chk(activeLanes == 8'h24, "R5 replay lanes 2,5", 64'(activeLanes), 64'h24);
    step("R3", 1'b0, 2'd0, 32'h0, 1'b1, 8'h01);  // lane 0 inactive
    step("R10", 1'b1, 2'd2, 32'h0, 1'b1, 8'h20); // same-cycle violation
    chk(activeLanes == 8'h20 && redirectPc == 32'h2000, "R6 second pass", 64'(activeLanes), 64'h20);
    step("R3", 1'b0, 2'd0, 32'h0, 1'b1, 8'h04);  // lane 2 now inactive
    step("R4", 1'b1, 2'd2, 32'h0, 1'b0, '0);
    chk(commitStb == 1'b1 && storeHold == 1'b0, "R7 commit drops hold", 64'(storeHold), 64'(0));

    // R8 nested start
    step("R8", 1'b1, 2'd1, 32'h3000, 1'b0, '0);
    step("R8", 1'b1, 2'd1, 32'h9999, 1'b1, 8'h02);
    step("R8", 1'b1, 2'd2, 32'h0, 1'b0, '0);
    chk(redirectPc == 32'h3000 && activeLanes == 8'h02, "R8 target kept", 64'(redirectPc), 64'h3000);
    step("R4", 1'b1, 2'd2, 32'h0, 1'b0, '0);

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic v, vv;
      logic [1:0] k;
      logic [LANES-1:0] vl;
      r  = int'($urandom % 16);
      k  = (r == 0) ? 2'd1 : (r < 3) ? 2'd2 : (r == 3) ? 2'd3 : 2'd0;
      v  = ($urandom % 8) != 0;
      vv = ($urandom % 5) == 0;
      vl = LANES'(1) << ($urandom % LANES);
      if (($urandom % 4) == 0) vl = vl | (LANES'(1) << ($urandom % LANES));
      step("rand", v, k, $urandom, vv, vl);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule